// File: doc/BRIEF.md
# Dual-Source Interrupt Level and Vector Unit

This unit merges the interrupt requests of two serial submodules, a synchronous SPI controller and a UART, into one prioritized bus request. Each source has its own programmable 3-bit priority level. The unit presents the higher active level on its request output. When both sources sit at the same level, the SPI source is preferred.

A system interrupt-acknowledge cycle carries an acknowledged level and the highest arbitration ID among the competing modules. The unit answers only when the acknowledged level matches its own request and its 4-bit arbitration ID beats that competitor. It then drives an 8-bit vector. The upper seven bits come from a programmable register, and the lowest bit identifies the source. An arbitration ID of zero keeps the unit out of arbitration entirely.

Configuration is reached through a small register port. Only accesses marked as supervisor may change it. A non-supervisor read returns zero and a non-supervisor write changes nothing.

Top module: `irq_merge_unit`

## Requirements
- R1: After reset the arbitration ID reads 0, both source levels read 0, the vector register reads 0x0F and the request level output is 0.
- R2: Register layout, all read and written as 8 bits. Address 0 holds the arbitration ID in bits 3:0. Address 1 holds the UART level in bits 2:0 and the SPI level in bits 6:4. Address 2 holds the vector. Address 3 and all unlisted bits read 0.
- R3: A source is active when its request input is high and its level is nonzero; level 0 masks it. The request level output equals the larger level among active sources, or 0 when none is active.
- R4: When both sources are active at the same level, the SPI source wins the acknowledge (vector bit 0 = 1).
- R5: A write to the vector register ignores bit 0, and reads of the vector register always return bit 0 as 1.
- R6: During a responded acknowledge, the vector output bits 7:1 equal the stored vector bits 7:1. Bit 0 is 1 when the SPI source is the winner and 0 when the UART source is.
- R7: With arbitration ID 0 the unit never responds to an acknowledge.
- R8: The unit responds only when all of the following hold:
  - acknowledge is high;
  - the acknowledged level equals the current nonzero request level;
  - its ID is strictly greater than the competing-ID input.

  When it does not respond, the hit output is 0 and the vector output is 0.
- R9: A read with the supervisor qualifier low returns 0. A write with the supervisor qualifier low changes no register.
- R10: An acknowledge clears nothing: levels, ID, vector and the request output are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_super | input | 1 | Access is made in supervisor mode |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| spi_req | input | 1 | SPI submodule interrupt pending |
| uart_req | input | 1 | UART submodule interrupt pending |
| irq_level | output | 3 | Requested interrupt level, 0 = none |
| iack | input | 1 | Interrupt-acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| iack_rival_id | input | 4 | Highest arbitration ID among competing modules |
| iack_hit | output | 1 | This unit answers the acknowledge |
| iack_vec | output | 8 | Vector driven during a responded acknowledge, else 0 |

## Verification
The hardest case to reach is an acknowledge that meets every condition but one. Examples are an ID equal to the competitor rather than above it, a level one step off, or a tie between the sources under an acknowledge. The bench reaches these by programming fixed levels and IDs, then sweeping the competing ID and the acknowledged level across each boundary while both requests are held. A behavioural model decides each expected response from the requirement rules, not from the unit's structure.

// File: rtl/irq_merge_unit.sv
`timescale 1ns/1ps
module irq_merge_unit #(
  parameter int LVL_W = 3,
  parameter int ID_W  = 4,
  parameter int DW    = 8,
  parameter int AW    = 2,
  parameter logic [DW-1:0] VEC_RST = 'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_super,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             spi_req,
  input  logic             uart_req,
  output logic [LVL_W-1:0] irq_level,
  input  logic             iack,
  input  logic [LVL_W-1:0] iack_level,
  input  logic [ID_W-1:0]  iack_rival_id,
  output logic             iack_hit,
  output logic [DW-1:0]    iack_vec
);
  localparam int SPI_LSB = LVL_W + 1;
  localparam logic [AW-1:0] A_ID  = AW'(0);
  localparam logic [AW-1:0] A_LVL = AW'(1);
  localparam logic [AW-1:0] A_VEC = AW'(2);

  logic [ID_W-1:0]  id_q;
  logic [LVL_W-1:0] spi_lvl_q, uart_lvl_q;
  logic [DW-1:1]    vec_q;

  wire wr_ok = cfg_we & cfg_super;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q       <= '0;
      spi_lvl_q  <= '0;
      uart_lvl_q <= '0;
      vec_q      <= VEC_RST[DW-1:1];
    end else if (wr_ok) begin
      case (cfg_addr)
        A_ID:  id_q <= cfg_wdata[ID_W-1:0];
        A_LVL: begin
          uart_lvl_q <= cfg_wdata[LVL_W-1:0];
          spi_lvl_q  <= cfg_wdata[SPI_LSB+LVL_W-1:SPI_LSB];
        end
        A_VEC: vec_q <= cfg_wdata[DW-1:1];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_super) begin
      case (cfg_addr)
        A_ID:  cfg_rdata[ID_W-1:0] = id_q;
        A_LVL: begin
          cfg_rdata[LVL_W-1:0]                 = uart_lvl_q;
          cfg_rdata[SPI_LSB+LVL_W-1:SPI_LSB]   = spi_lvl_q;
        end
        A_VEC: cfg_rdata = {vec_q, 1'b1};
        default: cfg_rdata = '0;
      endcase
    end
  end

  wire spi_act  = spi_req  & (spi_lvl_q  != '0);
  wire uart_act = uart_req & (uart_lvl_q != '0);
  wire [LVL_W-1:0] spi_eff  = spi_act  ? spi_lvl_q  : '0;
  wire [LVL_W-1:0] uart_eff = uart_act ? uart_lvl_q : '0;
  wire spi_wins = spi_act & (spi_eff >= uart_eff);

  assign irq_level = spi_wins ? spi_eff : uart_eff;

  assign iack_hit = iack & (id_q != '0) & (irq_level != '0)
                  & (iack_level == irq_level) & (id_q > iack_rival_id);
  assign iack_vec = iack_hit ? {vec_q, spi_wins} : '0;
endmodule

// File: rtl/irq_merge_chk.sv
`timescale 1ns/1ps
module irq_merge_chk #(
  parameter int LVL_W = 3,
  parameter int ID_W  = 4,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_super,
  input logic [DW-1:0]    cfg_rdata,
  input logic             spi_req,
  input logic             uart_req,
  input logic [LVL_W-1:0] irq_level,
  input logic             iack,
  input logic [LVL_W-1:0] iack_level,
  input logic [ID_W-1:0]  iack_rival_id,
  input logic             iack_hit,
  input logic [DW-1:0]    iack_vec,
  input logic [ID_W-1:0]  id_q,
  input logic [LVL_W-1:0] spi_lvl_q,
  input logic [LVL_W-1:0] uart_lvl_q,
  input logic [DW-1:1]    vec_q
);
  AST_LVL_COVERS_SPI: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && spi_lvl_q != 0) |-> irq_level >= spi_lvl_q); // R3
  AST_LVL_COVERS_UART: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_req && uart_lvl_q != 0) |-> irq_level >= uart_lvl_q); // R3
  AST_TIE_TO_SPI: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_hit && spi_req && uart_req && spi_lvl_q == uart_lvl_q) |-> iack_vec[0]); // R4
  AST_VEC_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    iack_hit |-> iack_vec[DW-1:1] == vec_q); // R6
  AST_ZERO_ID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (id_q == 0) |-> !iack_hit); // R7
  AST_NO_HIT_ZERO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_hit |-> iack_vec == 0); // R8
  AST_HIT_BEATS_RIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    iack_hit |-> (id_q > iack_rival_id && iack_level == irq_level)); // R8
  AST_USER_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_super |-> cfg_rdata == 0); // R9
  AST_USER_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_super) |=> ($stable(id_q) && $stable(spi_lvl_q)
                                && $stable(uart_lvl_q) && $stable(vec_q))); // R9
  AST_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !cfg_we) |=> ($stable(spi_lvl_q) && $stable(uart_lvl_q)
                           && $stable(id_q) && $stable(vec_q))); // R10
endmodule

bind irq_merge_unit irq_merge_chk #(.LVL_W(LVL_W), .ID_W(ID_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_super(cfg_super),
  .cfg_rdata(cfg_rdata), .spi_req(spi_req), .uart_req(uart_req),
  .irq_level(irq_level), .iack(iack), .iack_level(iack_level),
  .iack_rival_id(iack_rival_id), .iack_hit(iack_hit), .iack_vec(iack_vec),
  .id_q(id_q), .spi_lvl_q(spi_lvl_q), .uart_lvl_q(uart_lvl_q), .vec_q(vec_q)
);

// File: tb/irq_merge_unit_test.sv
`timescale 1ns/1ps
module irq_merge_unit_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_super = 0;
  logic [1:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic spi_req = 0, uart_req = 0, iack = 0, iack_hit;
  logic [2:0] irq_level, iack_level = 0;
  logic [3:0] iack_rival_id = 0;
  logic [7:0] iack_vec;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  int m_id, m_slvl, m_ulvl, m_vec;

  always #10 clk = ~clk;

  irq_merge_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_super(cfg_super),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .spi_req(spi_req), .uart_req(uart_req), .irq_level(irq_level),
    .iack(iack), .iack_level(iack_level), .iack_rival_id(iack_rival_id),
    .iack_hit(iack_hit), .iack_vec(iack_vec)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_id = 0; m_slvl = 0; m_ulvl = 0; m_vec = 'h0F;
    end else if (cfg_we && cfg_super) begin
      if (cfg_addr == 0) m_id = cfg_wdata & 'hF;
      else if (cfg_addr == 1) begin
        m_ulvl = cfg_wdata & 7;
        m_slvl = (cfg_wdata >> 4) & 7;
      end else if (cfg_addr == 2) m_vec = cfg_wdata | 1;
    end
  end

  task automatic compare(input string tag);
    int sa, ua, lvl, hit, exp_vec, exp_rd;
    bit spiwin;
    sa = (spi_req && m_slvl != 0) ? m_slvl : 0;
    ua = (uart_req && m_ulvl != 0) ? m_ulvl : 0;
    lvl = (sa > ua) ? sa : ua;
    spiwin = (sa != 0) && (sa >= ua);
    hit = (iack && m_id != 0 && lvl != 0 && iack_level == lvl && m_id > iack_rival_id) ? 1 : 0;
    exp_vec = hit ? ((m_vec & 'hFE) | spiwin) : 0;
    if (!cfg_super) exp_rd = 0;
    else case (cfg_addr)
      0: exp_rd = m_id;
      1: exp_rd = (m_slvl << 4) | m_ulvl;
      2: exp_rd = m_vec;
      default: exp_rd = 0;
    endcase
    vectors++;
    if (irq_level !== 3'(lvl) || iack_hit !== 1'(hit) ||
        iack_vec !== 8'(exp_vec) || cfg_rdata !== 8'(exp_rd)) begin
      miscompares++;
      $display("FAIL %s: got lvl=%0d hit=%0d vec=%h rd=%h, expected lvl=%0d hit=%0d vec=%h rd=%h",
               tag, irq_level, iack_hit, iack_vec, cfg_rdata, lvl, hit, exp_vec, exp_rd);
    end
  endtask

  task automatic step(input bit we, input bit sup, input int addr, input int wd,
                      input bit sr, input bit ur, input bit ack, input int al,
                      input int rival, input string tag);
    @(negedge clk);
    cfg_we = we; cfg_super = sup; cfg_addr = 2'(addr); cfg_wdata = 8'(wd);
    spi_req = sr; uart_req = ur; iack = ack; iack_level = 3'(al);
    iack_rival_id = 4'(rival);
    #2 compare(tag);
  endtask

  task automatic wr(input int addr, input int wd, input string tag);
    step(1, 1, addr, wd, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(input int addr, input bit sup, input string tag);
    step(0, sup, addr, 0, spi_req, uart_req, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values and R2 layout
    for (int a = 0; a < 4; a++) rd(a, 1, "R1");
    step(0, 1, 0, 0, 1, 1, 0, 0, 0, "R1");
    // R5 vector LSB forced
    wr(2, 'hA4, "R5"); rd(2, 1, "R5");
    wr(2, 'h53, "R5"); rd(2, 1, "R5");
    // R9 user access
    step(1, 0, 0, 5, 0, 0, 0, 0, 0, "R9"); rd(0, 1, "R9");
    step(1, 0, 2, 'hFE, 0, 0, 0, 0, 0, "R9"); rd(2, 1, "R9");
    rd(2, 0, "R9"); rd(1, 0, "R9");
    // R2 levels layout, R3 max
    wr(0, 9, "R2"); wr(1, 'h35, "R2"); rd(1, 1, "R2"); rd(0, 1, "R2");
    step(0, 1, 1, 0, 1, 1, 0, 0, 0, "R3");
    step(0, 1, 1, 0, 1, 0, 0, 0, 0, "R3");
    step(0, 1, 1, 0, 0, 1, 0, 0, 0, "R3");
    wr(1, 'h30, "R3");
    step(0, 1, 1, 0, 0, 1, 0, 0, 0, "R3");
    step(0, 1, 1, 0, 1, 1, 0, 0, 0, "R3");
    // R6 UART wins at level 5
    wr(1, 'h35, "R6");
    step(0, 1, 0, 0, 1, 1, 1, 5, 3, "R6");
    step(0, 1, 0, 0, 0, 1, 1, 5, 0, "R6");
    step(0, 1, 0, 0, 1, 0, 1, 3, 8, "R6");
    // R8 boundary sweeps
    for (int r = 0; r < 16; r++) step(0, 1, 0, 0, 1, 1, 1, 5, r, "R8");
    for (int l = 0; l < 8; l++) step(0, 1, 0, 0, 1, 1, 1, l, 2, "R8");
    step(0, 1, 0, 0, 1, 1, 0, 5, 2, "R8");
    // R4 tie
    wr(1, 'h44, "R4");
    step(0, 1, 0, 0, 1, 1, 1, 4, 1, "R4");
    step(0, 1, 0, 0, 1, 1, 1, 4, 9, "R4");
    // R10 held acknowledge clears nothing
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 1, 1, 1, 4, 0, "R10");
    rd(0, 1, "R10"); rd(2, 1, "R10");
    // R7 ID zero
    wr(0, 0, "R7");
    step(0, 1, 0, 0, 1, 1, 1, 4, 0, "R7");
    wr(0, 15, "R7");
    step(0, 1, 0, 0, 1, 1, 1, 4, 14, "R7");
    // mixed level sweep
    for (int s = 0; s < 8; s++)
      for (int u = 0; u < 8; u += 3) begin
        wr(1, (s << 4) | u, "R3");
        step(0, 1, 1, 0, 1, 1, 1, (s > u) ? s : u, 7, "R4");
        step(0, 1, 1, 0, 1, 1, 1, (s > u) ? s : u, 15, "R8");
      end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule